// File: doc/BRIEF.md
# Converter Power Shutdown Controller

This controller sequences the low-power states of a sampling converter's digital core. A request line, active low, asks for shutdown. A select line chooses how deep the shutdown goes. A shallow (nap) shutdown removes the analog bias but keeps the reference powered, so the core can return quickly. A deep (sleep) shutdown turns off both the bias and the reference. Returning from deep shutdown takes much longer, because the reference has to settle again.

The depth is sampled once, on the cycle the controller leaves normal or wake operation for shutdown. It is then held until the next entry. When the request is released, both power enables switch on at once. A wake counter then runs for the number of clock cycles set for the held depth. A ready flag stays low until that count ends. While ready is low, conversion start requests are not passed on, and each such request sets a sticky error flag that only reset clears. If shutdown is requested again during a wake, the controller returns to shutdown with a freshly sampled depth. The next wake then counts its full interval again.

The state machine has four states:
- ST_ACTIVE: fully powered and ready.
- ST_NAP: bias off, reference on.
- ST_SLEEP: bias and reference off.
- ST_WAKE: both powered, counting, not ready.

Its transitions are:
- ACTIVE→NAP or ACTIVE→SLEEP: request low; the select line picks which.
- NAP→WAKE and SLEEP→WAKE: request high.
- WAKE→NAP or WAKE→SLEEP: request low again; the select line is sampled anew.
- WAKE→ACTIVE: the count ends.

Top module: `pwr_shdn_ctrl`

## Requirements
- R1: After reset the controller is in normal operation: bias_en=1, ref_en=1, ready=1, start_err=0.
- R2: If the clock edge that samples shdn_n=0 in normal operation also samples nap_sel=1, the controller enters nap after that edge: bias_en=0, ref_en=1, ready=0.
- R3: If that edge samples nap_sel=0, the controller enters sleep: bias_en=0, ref_en=0, ready=0.
- R4: While shdn_n stays low, changes on nap_sel have no effect. ref_en keeps the value set at entry, and the next wake length follows the depth held at entry.
- R5: The first edge that samples shdn_n=1 in nap turns bias_en and ref_en on with ready=0. ready rises after exactly NAP_WAKE_CYC further edges, so it is high at the edge NAP_WAKE_CYC after the sampling edge.
- R6: Waking from sleep behaves in the same way, but ready rises SLEEP_WAKE_CYC edges after the sampling edge.
- R7: conv_go equals conv_req while ready=1 and is 0 while ready=0.
- R8: A conv_req sampled while ready=0 sets start_err at that edge. start_err stays 1 until reset, including after ready returns.
- R9: shdn_n=0 sampled during a wake returns the controller to shutdown, with the depth taken from nap_sel at that edge. The following wake counts its full interval from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn_n | input | 1 | Shutdown request, active low |
| nap_sel | input | 1 | Depth select: 1 selects nap, 0 selects sleep |
| conv_req | input | 1 | Conversion start request |
| bias_en | output | 1 | Analog bias power enable |
| ref_en | output | 1 | Reference power enable |
| ready | output | 1 | Conversions may start |
| conv_go | output | 1 | Accepted conversion start |
| start_err | output | 1 | Sticky flag: a start arrived while not ready |

## Verification
Shutdown is entered with each select level. This tells the two depths apart by the reference enable and by the wake length, which the bench measures edge by edge against each parameter. The select line is also toggled after entry, in both directions. A design that keeps following the live select line then shows a changed reference enable or the other wake length. Shutdown is requested again in the middle of a deep wake with the opposite select level, which checks both the resampling of the depth and the restart of the count. Start requests are issued both while ready and during a wake, which exercises both the gating and the sticky behaviour of the error flag.

// File: rtl/pwr_shdn_pkg.sv
package pwr_shdn_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_NAP    = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_WAKE   = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/pwr_mode_latch.sv
module pwr_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic nap_sel,
    output logic deep_q
);
    // Depth is held from shutdown entry until the next entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       deep_q <= 1'b0;
        else if (capture) deep_q <= ~nap_sel;
    end
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int NAP_CYC   = 10,
    parameter int SLEEP_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic deep,
    output logic done
);
    localparam int MAX_CYC = (NAP_CYC > SLEEP_CYC) ? NAP_CYC : SLEEP_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] NAP_LAST   = CW'(NAP_CYC - 1);
    localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = deep ? SLEEP_LAST : NAP_LAST;
    assign done = run && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (!done)    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwr_start_gate.sv
module pwr_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic conv_req,
    output logic conv_go,
    output logic err_q
);
    assign conv_go = conv_req && ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  err_q <= 1'b0;
        else if (conv_req && !ready) err_q <= 1'b1;
    end
endmodule

// File: rtl/pwr_shdn_ctrl.sv
module pwr_shdn_ctrl #(
    parameter int NAP_WAKE_CYC   = 10,
    parameter int SLEEP_WAKE_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n,
    input  logic nap_sel,
    input  logic conv_req,
    output logic bias_en,
    output logic ref_en,
    output logic ready,
    output logic conv_go,
    output logic start_err
);
    import pwr_shdn_pkg::*;

    pwr_state_e state_q, state_d;
    logic       deep_q;
    logic       wake_done;
    logic       enter_shdn;

    assign enter_shdn = !shdn_n && (state_q == ST_ACTIVE || state_q == ST_WAKE);

    pwr_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (enter_shdn),
        .nap_sel (nap_sel),
        .deep_q  (deep_q)
    );

    pwr_wake_timer #(
        .NAP_CYC   (NAP_WAKE_CYC),
        .SLEEP_CYC (SLEEP_WAKE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_WAKE),
        .deep  (deep_q),
        .done  (wake_done)
    );

    pwr_start_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready),
        .conv_req (conv_req),
        .conv_go  (conv_go),
        .err_q    (start_err)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (!shdn_n) state_d = nap_sel ? ST_NAP : ST_SLEEP;
            ST_NAP:    if (shdn_n)  state_d = ST_WAKE;
            ST_SLEEP:  if (shdn_n)  state_d = ST_WAKE;
            ST_WAKE: begin
                if (!shdn_n)        state_d = nap_sel ? ST_NAP : ST_SLEEP;
                else if (wake_done) state_d = ST_ACTIVE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        bias_en = 1'b1;
        ref_en  = 1'b1;
        ready   = 1'b0;
        unique case (state_q)
            ST_ACTIVE: ready   = 1'b1;
            ST_NAP:    bias_en = 1'b0;
            ST_SLEEP: begin
                bias_en = 1'b0;
                ref_en  = 1'b0;
            end
            ST_WAKE:   ready   = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwr_shdn_ctrl_chk.sv
module pwr_shdn_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic shdn_n,
    input logic nap_sel,
    input logic conv_req,
    input logic bias_en,
    input logic ref_en,
    input logic ready,
    input logic conv_go,
    input logic start_err
);
    // R5: ready only with full power
    p_ready_pwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (bias_en && ref_en));

    // R2, R3: entry from normal operation picks depth from nap_sel
    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !shdn_n) |=> (!ready && !bias_en && (ref_en == $past(nap_sel))));

    // R4: held shutdown keeps its depth
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_en && !shdn_n) |=> (!bias_en && $stable(ref_en)));

    // R5, R6: release powers up without ready
    p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_en && shdn_n) |=> (bias_en && ref_en && !ready));

    // R7: starts pass only while ready
    p_go_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> (ready && conv_req));

    // R8: blocked start sets flag, flag is sticky
    p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !ready) |=> start_err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |=> start_err);
endmodule

bind pwr_shdn_ctrl pwr_shdn_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shdn_n    (shdn_n),
    .nap_sel   (nap_sel),
    .conv_req  (conv_req),
    .bias_en   (bias_en),
    .ref_en    (ref_en),
    .ready     (ready),
    .conv_go   (conv_go),
    .start_err (start_err)
);

// File: tb/pwr_shdn_ctrl_tb.sv
module pwr_shdn_ctrl_tb;
    localparam int NAP_W   = 10;
    localparam int SLEEP_W = 60;

    logic clk = 1'b0;
    logic rst_n;
    logic shdn_n;
    logic nap_sel;
    logic conv_req;
    logic bias_en, ref_en, ready, conv_go, start_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwr_shdn_ctrl #(
        .NAP_WAKE_CYC   (NAP_W),
        .SLEEP_WAKE_CYC (SLEEP_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .shdn_n    (shdn_n),
        .nap_sel   (nap_sel),
        .conv_req  (conv_req),
        .bias_en   (bias_en),
        .ref_en    (ref_en),
        .ready     (ready),
        .conv_go   (conv_go),
        .start_err (start_err)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; shdn_n = 1'b1; nap_sel = 1'b1; conv_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Releases shutdown and returns the negedge index at which ready was seen high.
    // The first negedge follows the sampling edge, so the index is limit+1.
    task automatic release_and_time(input string req, output int n);
        n = -1;
        shdn_n = 1'b1;
        for (int i = 1; i <= 1000; i++) begin
            @(negedge clk);
            if (i == 1) begin
                chk(req, "bias_en on first wake cycle", bias_en, 1);
                chk(req, "ref_en on first wake cycle", ref_en, 1);
            end
            if (ready) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "bias_en", bias_en, 1);
        chk("R1", "ref_en", ref_en, 1);
        chk("R1", "ready", ready, 1);
        chk("R1", "start_err", start_err, 0);
    endtask

    task automatic t_nap();
        int n;
        nap_sel = 1'b1; shdn_n = 1'b0;
        @(negedge clk);
        chk("R2", "bias_en in nap", bias_en, 0);
        chk("R2", "ref_en in nap", ref_en, 1);
        chk("R2", "ready in nap", ready, 0);
        nap_sel = 1'b0;  // R4: must be ignored
        repeat (4) @(negedge clk);
        chk("R4", "ref_en after select change in nap", ref_en, 1);
        chk("R4", "bias_en after select change in nap", bias_en, 0);
        release_and_time("R5", n);
        chk("R5", "nap wake edges (limit+1)", n, NAP_W + 1);
        chk("R4", "start_err untouched", start_err, 0);
    endtask

    task automatic t_sleep();
        int n;
        nap_sel = 1'b0; shdn_n = 1'b0;
        @(negedge clk);
        chk("R3", "bias_en in sleep", bias_en, 0);
        chk("R3", "ref_en in sleep", ref_en, 0);
        chk("R3", "ready in sleep", ready, 0);
        nap_sel = 1'b1;  // R4: must be ignored
        repeat (3) @(negedge clk);
        chk("R4", "ref_en after select change in sleep", ref_en, 0);
        release_and_time("R6", n);
        chk("R6", "sleep wake edges (limit+1)", n, SLEEP_W + 1);
    endtask

    task automatic t_reassert();
        int n;
        nap_sel = 1'b0; shdn_n = 1'b0;
        @(negedge clk);
        shdn_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9", "ready mid deep wake", ready, 0);
        nap_sel = 1'b1; shdn_n = 1'b0;
        @(negedge clk);
        chk("R9", "bias_en after re-entry", bias_en, 0);
        chk("R9", "ref_en after re-entry (nap resampled)", ref_en, 1);
        release_and_time("R9", n);
        chk("R9", "full nap wake after re-entry", n, NAP_W + 1);
    endtask

    task automatic t_start();
        int n;
        conv_req = 1'b1;
        #1;
        chk("R7", "conv_go while ready", conv_go, 1);
        @(negedge clk);
        conv_req = 1'b0;
        chk("R8", "no error from accepted start", start_err, 0);
        nap_sel = 1'b1; shdn_n = 1'b0;
        @(negedge clk);
        shdn_n = 1'b1;
        @(negedge clk);
        conv_req = 1'b1;
        #1;
        chk("R7", "conv_go blocked during wake", conv_go, 0);
        @(negedge clk);
        conv_req = 1'b0;
        chk("R8", "start_err set by blocked start", start_err, 1);
        for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
        chk("R8", "ready returned", ready, 1);
        chk("R8", "start_err still set when ready", start_err, 1);
        conv_req = 1'b1;
        #1;
        chk("R7", "conv_go after wake", conv_go, 1);
        @(negedge clk);
        conv_req = 1'b0;
        do_reset();
        chk("R8", "start_err cleared by reset", start_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_nap();
        t_sleep();
        t_reassert();
        t_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule